// File: doc/BRIEF.md
# Windowed Register File

A 32-bit register file whose architectural view slides over a larger physical array, so that a procedure call gets a fresh set of working registers without any copying. Physical storage is 136 words: eight globals seen from every window, plus eight windows of sixteen private words each (eight locals and eight outgoing registers). A window's incoming registers are the outgoing registers of the window one position above it, so arguments placed in the caller's outgoing registers appear in the callee's incoming registers after a save.

Two combinational read ports and one synchronous write port take 5-bit architectural register numbers, which are translated through the current-window pointer. A save moves the pointer down by one and a restore moves it up by one, both modulo eight. An 8-bit invalid-window mask marks windows that may not be entered. A move onto a marked window is refused and raises a one-cycle overflow (save) or underflow (restore) flag, leaving the spill or fill to trap software.

Top module: `win_regfile`

## Requirements
- R1: After reset the window pointer is 0, both flags are low and every architectural register reads 0.
- R2: Architectural register 0 always reads 0; a write to it changes nothing and is not forwarded to a read port.
- R3: Architectural registers 1 to 7 are globals: one value per number, identical from every window.
- R4: Architectural registers 16 to 23 are locals, private to each window; a write in one window is not seen in another.
- R5: Registers 8 to 15 of window w are the same storage as registers 24 to 31 of window (w-1) mod 8, index for index.
- R6: A save sets the pointer to (pointer-1) mod 8 at the next clock edge, a restore to (pointer+1) mod 8; when both are requested the save is performed and the restore is dropped; with neither the pointer holds.
- R7: A save whose target window has its mask bit set leaves the pointer unchanged and drives the overflow flag high for exactly the next cycle; a restore in the same situation does the same with the underflow flag. Both flags are low otherwise.
- R8: A read of the register being written in the same cycle returns the new write data (write-first).
- R9: A write issued in the same cycle as a save or restore lands in the window the pointer held before that edge.

Top module port order follows below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rs1_i | input | 5 | Read port 1 architectural register number |
| rs2_i | input | 5 | Read port 2 architectural register number |
| rd1_o | output | 32 | Read port 1 data |
| rd2_o | output | 32 | Read port 2 data |
| we_i | input | 1 | Write enable |
| wa_i | input | 5 | Write architectural register number |
| wd_i | input | 32 | Write data |
| save_i | input | 1 | Move to the next deeper window |
| restore_i | input | 1 | Return to the caller window |
| wim_i | input | 8 | Invalid-window mask, bit n marks window n |
| cwp_o | output | 3 | Current window pointer |
| ovf_o | output | 1 | Refused save, one-cycle pulse |
| unf_o | output | 1 | Refused restore, one-cycle pulse |

## Verification
The bench aims at pointer wrap in both directions (0 to 7 on save, 7 to 0 on restore); a translator that fails to wrap the incoming-register window would read the wrong physical bank at window 7. It drives a save and a restore together and checks that only the save takes effect, and it refuses moves onto marked windows, where a faulty design would move the pointer anyway or pulse the wrong flag. Writes to register 0 with a same-cycle read catch a bypass that forwards discarded data, and a write issued together with a save catches a design that writes into the new window instead of the old one.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int AREG_W   = 5;
  localparam int GRP      = 8;   // registers per group
  localparam int GRP_W    = 3;
  localparam int WIN_SPAN = 2 * GRP;

  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_OUT = 2'd1,
    GRP_LOC = 2'd2,
    GRP_IN  = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/wrf_xlate.sv
module wrf_xlate
  import wrf_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int CWP_W  = $clog2(NWIN),
  parameter int PHYS_W = 8
) (
  input  logic [CWP_W-1:0]  win_i,
  input  logic [AREG_W-1:0] areg_i,
  output logic [PHYS_W-1:0] phys_o
);
  function automatic logic [PHYS_W-1:0] win_base(input logic [CWP_W-1:0] w);
    return PHYS_W'(GRP) + PHYS_W'(w) * PHYS_W'(WIN_SPAN);
  endfunction

  logic [CWP_W-1:0]  win_up;
  logic [PHYS_W-1:0] idx;

  always_comb begin
    win_up = win_i + CWP_W'(1);  // caller window, wraps
    idx    = PHYS_W'(areg_i[GRP_W-1:0]);
    unique case (reg_grp_e'(areg_i[AREG_W-1:GRP_W]))
      GRP_GLB: phys_o = idx;
      GRP_LOC: phys_o = win_base(win_i) + idx;
      GRP_OUT: phys_o = win_base(win_i) + PHYS_W'(GRP) + idx;
      default: phys_o = win_base(win_up) + PHYS_W'(GRP) + idx;
    endcase
  end
endmodule

// File: rtl/wrf_cwp.sv
module wrf_cwp #(
  parameter int NWIN  = 8,
  parameter int CWP_W = $clog2(NWIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic [NWIN-1:0]  wim_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [CWP_W-1:0] cwp_q, cwp_d, cwp_dn, cwp_up;
  logic             ovf_d, unf_d;

  always_comb begin
    cwp_dn = cwp_q - CWP_W'(1);
    cwp_up = cwp_q + CWP_W'(1);
    cwp_d  = cwp_q;
    ovf_d  = 1'b0;
    unf_d  = 1'b0;
    if (save_i) begin
      if (wim_i[cwp_dn]) ovf_d = 1'b1;
      else               cwp_d = cwp_dn;
    end else if (restore_i) begin
      if (wim_i[cwp_up]) unf_d = 1'b1;
      else               cwp_d = cwp_up;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      cwp_q <= cwp_d;
      ovf_o <= ovf_d;
      unf_o <= unf_d;
    end
  end

  assign cwp_o = cwp_q;
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
  parameter int DATA_W = 32,
  parameter int NPHYS  = 136,
  parameter int PHYS_W = 8,
  parameter int NRD    = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [PHYS_W-1:0]             wa_i,
  input  logic [DATA_W-1:0]             wd_i,
  input  logic [NRD-1:0][PHYS_W-1:0]    ra_i,
  output logic [NRD-1:0][DATA_W-1:0]    rd_o
);
  logic [DATA_W-1:0] mem [NPHYS];
  logic              wr_live;

  // physical 0 is the hard-wired zero global
  assign wr_live = we_i && (wa_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
    end else if (wr_live) begin
      mem[wa_i] <= wd_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (wr_live && (wa_i == ra_i[p])) rd_o[p] = wd_i;
      else                              rd_o[p] = mem[ra_i[p]];
    end
  end
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NWIN   = 8,
  localparam int CWP_W  = $clog2(NWIN),
  localparam int NPHYS  = GRP + NWIN * WIN_SPAN,
  localparam int PHYS_W = $clog2(NPHYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        rs1_i,
  input  logic [4:0]        rs2_i,
  output logic [DATA_W-1:0] rd1_o,
  output logic [DATA_W-1:0] rd2_o,
  input  logic              we_i,
  input  logic [4:0]        wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic              save_i,
  input  logic              restore_i,
  input  logic [NWIN-1:0]   wim_i,
  output logic [CWP_W-1:0]  cwp_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int NRD = 2;

  logic [NRD-1:0][AREG_W-1:0] ra_arch;
  logic [NRD-1:0][PHYS_W-1:0] ra_phys;
  logic [NRD-1:0][DATA_W-1:0] rd_data;
  logic [PHYS_W-1:0]          wa_phys;

  assign ra_arch = {rs2_i, rs1_i};

  wrf_cwp #(.NWIN(NWIN)) u_cwp (
    .clk_i(clk_i), .rst_ni(rst_ni), .save_i(save_i), .restore_i(restore_i),
    .wim_i(wim_i), .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rx
    wrf_xlate #(.NWIN(NWIN), .PHYS_W(PHYS_W)) u_xl (
      .win_i(cwp_o), .areg_i(ra_arch[p]), .phys_o(ra_phys[p])
    );
  end

  wrf_xlate #(.NWIN(NWIN), .PHYS_W(PHYS_W)) u_wxl (
    .win_i(cwp_o), .areg_i(wa_i), .phys_o(wa_phys)
  );

  wrf_store #(.DATA_W(DATA_W), .NPHYS(NPHYS), .PHYS_W(PHYS_W), .NRD(NRD)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .wa_i(wa_phys), .wd_i(wd_i),
    .ra_i(ra_phys), .rd_o(rd_data)
  );

  assign rd1_o = rd_data[0];
  assign rd2_o = rd_data[1];
endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int NWIN   = 8,
  parameter int CWP_W  = $clog2(NWIN)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        rs1_i,
  input logic [DATA_W-1:0] rd1_o,
  input logic              save_i,
  input logic              restore_i,
  input logic [NWIN-1:0]   wim_i,
  input logic [CWP_W-1:0]  cwp_o,
  input logic              ovf_o,
  input logic              unf_o
);
  logic [CWP_W-1:0] tgt_dn, tgt_up;
  logic             bad_dn, bad_up;
  assign tgt_dn = cwp_o - CWP_W'(1);
  assign tgt_up = cwp_o + CWP_W'(1);
  assign bad_dn = wim_i[tgt_dn];
  assign bad_up = wim_i[tgt_up];

  AST_ZERO_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs1_i == 5'd0) |-> (rd1_o == '0)); // R2
  AST_SAVE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !bad_dn) |=> (cwp_o == CWP_W'($past(cwp_o) - CWP_W'(1)))); // R6
  AST_RESTORE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!save_i && restore_i && !bad_up) |=> (cwp_o == CWP_W'($past(cwp_o) + CWP_W'(1)))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!save_i && !restore_i) |=> $stable(cwp_o)); // R6
  AST_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && bad_dn) |=> (ovf_o && !unf_o && $stable(cwp_o))); // R7
  AST_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!save_i && restore_i && bad_up) |=> (unf_o && !ovf_o && $stable(cwp_o))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(save_i && bad_dn) |=> !ovf_o); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!save_i && restore_i && bad_up) |=> !unf_o); // R7
endmodule

bind win_regfile win_regfile_chk #(.DATA_W(DATA_W), .NWIN(NWIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rs1_i(rs1_i), .rd1_o(rd1_o),
  .save_i(save_i), .restore_i(restore_i), .wim_i(wim_i),
  .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/tb_win_regfile.sv
`timescale 1ns/1ps
module tb_win_regfile;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rs1_i = '0, rs2_i = '0, wa_i = '0;
  logic [31:0] rd1_o, rd2_o, wd_i = '0;
  logic        we_i = 1'b0, save_i = 1'b0, restore_i = 1'b0;
  logic [7:0]  wim_i = '0;
  logic [2:0]  cwp_o;
  logic        ovf_o, unf_o;

  always #2 clk_i = ~clk_i;

  win_regfile dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state from the requirements
  logic [31:0] m_glb [8];
  logic [31:0] m_out [8][8];
  logic [31:0] m_loc [8][8];
  int e_cwp = 0;
  bit e_ovf = 0, e_unf = 0;

  function automatic int slot(int w, int r);
    if (r < 8)  return r;
    if (r < 16) return 100 + w * 8 + (r - 8);
    if (r < 24) return 200 + w * 8 + (r - 16);
    return 100 + ((w + 1) % 8) * 8 + (r - 24);
  endfunction

  function automatic logic [31:0] m_rd(int w, int r);
    if (r == 0)  return '0;
    if (r < 8)   return m_glb[r];
    if (r < 16)  return m_out[w][r - 8];
    if (r < 24)  return m_loc[w][r - 16];
    return m_out[(w + 1) % 8][r - 24];
  endfunction

  task automatic m_wr(int w, int r, logic [31:0] d);
    if (r == 0) return;
    if (r < 8)       m_glb[r] = d;
    else if (r < 16) m_out[w][r - 8] = d;
    else if (r < 24) m_loc[w][r - 16] = d;
    else             m_out[(w + 1) % 8][r - 24] = d;
  endtask

  function automatic logic [31:0] exp_rd(int r, bit we, int wa, logic [31:0] wd);
    if (we && wa != 0 && r != 0 && slot(e_cwp, r) == slot(e_cwp, wa)) return wd;
    return m_rd(e_cwp, r);
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, int r1, int r2, bit we, int wa, logic [31:0] wd,
                      bit sv, bit rs, logic [7:0] wim);
    logic [31:0] x1, x2;
    int nx;
    @(negedge clk_i);
    chk(cwp_o == 3'(e_cwp), tag, "cwp", 32'(cwp_o), 32'(e_cwp));
    chk(ovf_o == e_ovf, tag, "ovf", 32'(ovf_o), 32'(e_ovf));
    chk(unf_o == e_unf, tag, "unf", 32'(unf_o), 32'(e_unf));
    rs1_i = 5'(r1); rs2_i = 5'(r2); we_i = we; wa_i = 5'(wa); wd_i = wd;
    save_i = sv; restore_i = rs; wim_i = wim;
    #1;
    x1 = exp_rd(r1, we, wa, wd);
    x2 = exp_rd(r2, we, wa, wd);
    chk(rd1_o === x1, tag, $sformatf("rd1 r%0d", r1), rd1_o, x1);
    chk(rd2_o === x2, tag, $sformatf("rd2 r%0d", r2), rd2_o, x2);
    @(posedge clk_i);
    if (we) m_wr(e_cwp, wa, wd);   // R9: old window
    e_ovf = 0; e_unf = 0;
    if (sv) begin
      nx = (e_cwp + 7) % 8;
      if (wim[nx]) e_ovf = 1; else e_cwp = nx;
    end else if (rs) begin
      nx = (e_cwp + 1) % 8;
      if (wim[nx]) e_unf = 1; else e_cwp = nx;
    end
  endtask

  task automatic idle(string tag, int r1, int r2);
    step(tag, r1, r2, 0, 0, '0, 0, 0, '0);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      m_glb[i] = '0;
      for (int j = 0; j < 8; j++) begin m_out[i][j] = '0; m_loc[i][j] = '0; end
    end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1: reset contents of window 0
    for (int r = 0; r < 32; r++) idle("R1", r, 31 - r);
    // R2: write to r0 discarded, not forwarded
    step("R2", 0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0, '0);
    idle("R2", 0, 0);
    // R3: global seen after moving window
    step("R3", 5, 5, 1, 5, 32'h5555_0005, 0, 0, '0);
    step("R6", 5, 0, 0, 0, '0, 1, 0, '0);          // save 0 -> 7 wrap
    idle("R3", 5, 3);
    // R5: outs of w7 appear as ins of w6
    step("R5", 9, 0, 1, 9, 32'h0000_0999, 0, 0, '0);
    step("R4", 18, 0, 1, 18, 32'h1818_0007, 0, 0, '0);
    step("R6", 0, 0, 0, 0, '0, 1, 0, '0);          // 7 -> 6
    idle("R5", 25, 9);
    idle("R4", 18, 22);
    // R6: both requested, save wins
    step("R6", 0, 0, 0, 0, '0, 1, 1, '0);
    idle("R6", 0, 0);
    // R7: refused save and restore
    step("R7", 0, 0, 0, 0, '0, 1, 0, 8'h10);       // cwp 5, target 4 marked
    idle("R7", 0, 0);
    step("R7", 0, 0, 0, 0, '0, 0, 1, 8'h40);       // target 6 marked
    idle("R7", 0, 0);
    // R8: write-first bypass on both ports
    step("R8", 20, 28, 1, 20, 32'hA5A5_2020, 0, 0, '0);
    step("R8", 28, 20, 1, 28, 32'h2828_5A5A, 0, 0, '0);
    // R9: write together with save lands in old window
    step("R9", 0, 0, 1, 17, 32'h0017_ABCD, 1, 0, '0);
    idle("R9", 17, 0);
    step("R9", 0, 0, 0, 0, '0, 0, 1, '0);
    idle("R9", 17, 0);
    // restore wrap 7 -> 0
    while (e_cwp != 7) step("R6", 0, 0, 0, 0, '0, 0, 1, '0);
    step("R6", 0, 0, 0, 0, '0, 0, 1, '0);
    idle("R6", 31, 15);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int r1, r2, wa;
      bit we, sv, rs;
      logic [7:0] wim;
      r1  = int'($urandom % 32);
      r2  = int'($urandom % 32);
      wa  = ($urandom % 4 == 0) ? r1 : int'($urandom % 32);
      we  = ($urandom % 2) == 0;
      sv  = ($urandom % 6) == 0;
      rs  = ($urandom % 6) == 0;
      wim = ($urandom % 5 == 0) ? 8'($urandom) : 8'h00;
      step("R3-R5 random", r1, r2, we, wa, $urandom, sv, rs, wim);
    end
    idle("R7", 0, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule